// File: doc/BRIEF.md
# Time-Sliced Event Counter Bank

This block counts more event types than it has hardware counters. A small set of physical counters is shared across a larger event vector by time-slicing. Time is cut into slices of a programmable number of clock cycles. A fixed number of rotation slots run in a repeating order, one slot per slice. Each slot holds its own table that says which event each physical counter watches while that slot is active.

When a slice ends, every counter adds its value into a running per-event total and clears in the same cycle. Software never has to read the counters between rotations. Events that are mutually exclusive in hardware are kept apart by placing them in different slots of the table.

Totals are read through a combinational read port indexed by event number. A one-cycle pulse marks each finished pass through all slots. Software writes the slice length and the selection table through a simple write port. Turning the totals into estimates for the time an event was not watched is left to software.

Top module: `mux_event_counter_bank`

## Requirements
- R1: Reset has the following effects. It clears every per-event total to 0, sets the active slot to 0 and holds `sweep_done` low. It loads the slice length with `DEF_SLICE` and sets every selection entry to all ones, which is an invalid event number, so no counter counts after reset.
- R2: A write with `cfg_addr` = 0 sets the slice length. A write with `cfg_addr` = 1 + slot*`NUM_CTRS` + counter sets that counter's event number for that slot. A write to any other address changes nothing. A slice length of 0 behaves as a length of 1.
- R3: With slice length L, each slice lasts exactly L clock cycles. The last cycle of the slice is the boundary cycle.
- R4: In each cycle, a counter whose selected event bit of `ev_i` is 1 adds one. This includes the boundary cycle. At the boundary edge the counter's value, including that cycle's event, is added to the selected event's total, and the counter returns to 0.
- R5: A selection value of `NUM_EVENTS` or more leaves that counter idle for the slot, and no total changes because of it.
- R6: `cur_slot` advances by one at every boundary edge and wraps from `NUM_SLOTS`-1 to 0.
- R7: `sweep_done` is high for exactly the one cycle that follows a boundary edge at which the slot wrapped from `NUM_SLOTS`-1 to 0.
- R8: A counter saturates at 2^`CTR_W`-1. The value it credits never exceeds that limit.
- R9: When several counters in one slot select the same event, that event's total receives the sum of all their values.
- R10: `rd_total` shows the total of event `rd_idx` in the same cycle. It shows 0 when `rd_idx` is `NUM_EVENTS` or more.
- R11: A configuration write takes effect from the cycle after the write cycle. Counting in the write cycle uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | NUM_EVENTS | One bit per event type, high in each cycle the event occurs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Write address: 0 is slice length, 1 and up are selection entries |
| cfg_wdata | input | SLICE_W | Write data; selection writes use the low SEL_W bits |
| rd_idx | input | SEL_W | Event number whose total is read |
| rd_total | output | TOT_W | Accumulated total of event `rd_idx` |
| cur_slot | output | SLOT_W | Currently active rotation slot |
| sweep_done | output | 1 | One-cycle pulse after each full pass through all slots |

## Verification
The bench keeps the default 24 events, 15 counters and 4 slots. It narrows the counter to 4 bits, the slice length to 8 bits and the totals to 20 bits. It starts with a default slice of 6 cycles. The 4-bit counter means a single slice of 40 cycles reaches saturation. The 5-bit select field means values 24 to 31 exercise invalid selections and out-of-range reads. Slice lengths of 0 and 1 exercise back-to-back boundaries, so `sweep_done` fires every fourth cycle. Random phases mix event densities with writes to random addresses in the middle of a slice, including addresses above the table.

// File: rtl/mux_ctr_pkg.sv
package mux_ctr_pkg;

    // Default geometry of the counter bank.
    localparam int DEF_NUM_EVENTS = 24;
    localparam int DEF_NUM_CTRS   = 15;
    localparam int DEF_NUM_SLOTS  = 4;

    // Kind of a configuration write.
    typedef enum logic [1:0] {
        CFG_NONE = 2'd0,
        CFG_LEN  = 2'd1,
        CFG_SEL  = 2'd2
    } cfg_kind_e;

    // Slice events produced by the timer for the counting datapath.
    typedef struct packed {
        logic boundary;   // last cycle of the current slice
        logic last_slot;  // active slot is the final one of the rotation
    } slice_evt_t;

    // Classify a configuration address against the number of table entries.
    function automatic cfg_kind_e cfg_classify(input int unsigned addr,
                                               input int unsigned n_entries);
        if (addr == 0)
            return CFG_LEN;
        else if (addr <= n_entries)
            return CFG_SEL;
        return CFG_NONE;
    endfunction

endpackage

// File: rtl/mcb_slice_timer.sv
module mcb_slice_timer
    import mux_ctr_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int SLICE_W   = 16,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SLICE_W-1:0] len_i,
    output slice_evt_t         evt_o,
    output logic [SLOT_W-1:0]  slot_o,
    output logic               sweep_done_o
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [SLICE_W-1:0] tick_q;
    logic [SLICE_W-1:0] len_eff;
    logic [SLOT_W-1:0]  slot_q;
    logic               done_q;

    // A programmed length of zero is treated as one cycle.
    assign len_eff = (len_i == '0) ? SLICE_W'(1) : len_i;

    // Using >= lets a shortened length end the slice at once.
    always_comb begin
        evt_o.boundary  = (tick_q >= (len_eff - SLICE_W'(1)));
        evt_o.last_slot = (slot_q == LAST_SLOT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            slot_q <= '0;
            done_q <= 1'b0;
        end else if (evt_o.boundary) begin
            tick_q <= '0;
            done_q <= evt_o.last_slot;
            slot_q <= evt_o.last_slot ? '0 : slot_q + SLOT_W'(1);
        end else begin
            tick_q <= tick_q + SLICE_W'(1);
            done_q <= 1'b0;
        end
    end

    assign slot_o       = slot_q;
    assign sweep_done_o = done_q;

endmodule

// File: rtl/mcb_sel_table.sv
module mcb_sel_table
    import mux_ctr_pkg::*;
#(
    parameter int NUM_CTRS  = DEF_NUM_CTRS,
    parameter int NUM_SLOTS = DEF_NUM_SLOTS,
    parameter int SEL_W     = 5,
    parameter int SLICE_W   = 16,
    parameter int ADDR_W    = 6,
    parameter int SLOT_W    = 2,
    parameter int DEF_SLICE = 1000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [SLICE_W-1:0] cfg_wdata,
    input  logic [SLOT_W-1:0]  slot_i,
    output logic [SLICE_W-1:0] len_o,
    output logic [SEL_W-1:0]   sel_o [NUM_CTRS]
);

    localparam int N_ENTRIES = NUM_SLOTS * NUM_CTRS;

    logic [SLICE_W-1:0] len_q;
    logic [SEL_W-1:0]   sel_q [NUM_SLOTS][NUM_CTRS];
    cfg_kind_e          kind;
    int                 entry;

    always_comb begin
        kind  = cfg_classify(32'(cfg_addr), N_ENTRIES);
        entry = int'(32'(cfg_addr)) - 1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            len_q <= SLICE_W'(DEF_SLICE);
        else if (cfg_we && kind == CFG_LEN)
            len_q <= cfg_wdata;
    end

    // One storage row per slot and counter; all ones means idle.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
            always_ff @(posedge clk) begin
                if (rst)
                    sel_q[s][c] <= '1;
                else if (cfg_we && kind == CFG_SEL && entry == s * NUM_CTRS + c)
                    sel_q[s][c] <= cfg_wdata[SEL_W-1:0];
            end
        end
    end

    // The selection of the active slot drives the counters.
    for (genvar c = 0; c < NUM_CTRS; c++) begin : g_out
        always_comb begin
            sel_o[c] = sel_q[0][c];
            for (int s = 1; s < NUM_SLOTS; s++)
                if (slot_i == SLOT_W'(s))
                    sel_o[c] = sel_q[s][c];
        end
    end

    assign len_o = len_q;

endmodule

// File: rtl/mcb_lane.sv
module mcb_lane
    import mux_ctr_pkg::*;
#(
    parameter int NUM_EVENTS = DEF_NUM_EVENTS,
    parameter int SEL_W      = 5,
    parameter int CTR_W      = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_EVENTS-1:0] ev_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  slice_evt_t            evt_i,
    output logic                  valid_o,
    output logic [CTR_W-1:0]      credit_o
);

    localparam int PAD_W = 2 ** SEL_W;
    localparam logic [CTR_W-1:0] CTR_MAX = '1;

    logic [PAD_W-1:0] ev_pad;
    logic [CTR_W-1:0] cnt_q;
    logic             hit;

    assign ev_pad  = PAD_W'(ev_i);
    assign valid_o = (32'(sel_i) < NUM_EVENTS);
    assign hit     = valid_o && ev_pad[sel_i];

    // Value this counter holds after the current cycle, with saturation.
    assign credit_o = (cnt_q == CTR_MAX) ? CTR_MAX : cnt_q + CTR_W'(hit);

    always_ff @(posedge clk) begin
        if (rst || evt_i.boundary)
            cnt_q <= '0;
        else
            cnt_q <= credit_o;
    end

endmodule

// File: rtl/mcb_shadow.sv
module mcb_shadow
    import mux_ctr_pkg::*;
#(
    parameter int NUM_EVENTS = DEF_NUM_EVENTS,
    parameter int NUM_CTRS   = DEF_NUM_CTRS,
    parameter int SEL_W      = 5,
    parameter int CTR_W      = 16,
    parameter int TOT_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  slice_evt_t       evt_i,
    input  logic [SEL_W-1:0] sel_i    [NUM_CTRS],
    input  logic             valid_i  [NUM_CTRS],
    input  logic [CTR_W-1:0] credit_i [NUM_CTRS],
    input  logic [SEL_W-1:0] rd_idx,
    output logic [TOT_W-1:0] rd_total
);

    logic [TOT_W-1:0] total_q [NUM_EVENTS];
    logic [TOT_W-1:0] add     [NUM_EVENTS];

    for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_evt
        // Sum of all counters that watched this event during the slice.
        always_comb begin
            add[e] = '0;
            for (int c = 0; c < NUM_CTRS; c++)
                if (valid_i[c] && sel_i[c] == SEL_W'(e))
                    add[e] = add[e] + TOT_W'(credit_i[c]);
        end

        always_ff @(posedge clk) begin
            if (rst)
                total_q[e] <= '0;
            else if (evt_i.boundary)
                total_q[e] <= total_q[e] + add[e];
        end
    end

    always_comb begin
        rd_total = '0;
        for (int e = 0; e < NUM_EVENTS; e++)
            if (rd_idx == SEL_W'(e))
                rd_total = total_q[e];
    end

endmodule

// File: rtl/mux_event_counter_bank.sv
module mux_event_counter_bank
    import mux_ctr_pkg::*;
#(
    parameter int NUM_EVENTS = DEF_NUM_EVENTS,
    parameter int NUM_CTRS   = DEF_NUM_CTRS,
    parameter int NUM_SLOTS  = DEF_NUM_SLOTS,
    parameter int CTR_W      = 16,
    parameter int TOT_W      = 32,
    parameter int SLICE_W    = 16,
    parameter int DEF_SLICE  = 1000,
    parameter int SEL_W      = $clog2(NUM_EVENTS + 1),
    parameter int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    parameter int ADDR_W     = $clog2(NUM_SLOTS * NUM_CTRS + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_EVENTS-1:0] ev_i,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [SLICE_W-1:0]    cfg_wdata,
    input  logic [SEL_W-1:0]      rd_idx,
    output logic [TOT_W-1:0]      rd_total,
    output logic [SLOT_W-1:0]     cur_slot,
    output logic                  sweep_done
);

    slice_evt_t         evt;
    logic [SLICE_W-1:0] len;
    logic [SEL_W-1:0]   sel    [NUM_CTRS];
    logic               valid  [NUM_CTRS];
    logic [CTR_W-1:0]   credit [NUM_CTRS];

    mcb_slice_timer #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLICE_W   (SLICE_W),
        .SLOT_W    (SLOT_W)
    ) i_timer (
        .clk          (clk),
        .rst          (rst),
        .len_i        (len),
        .evt_o        (evt),
        .slot_o       (cur_slot),
        .sweep_done_o (sweep_done)
    );

    mcb_sel_table #(
        .NUM_CTRS  (NUM_CTRS),
        .NUM_SLOTS (NUM_SLOTS),
        .SEL_W     (SEL_W),
        .SLICE_W   (SLICE_W),
        .ADDR_W    (ADDR_W),
        .SLOT_W    (SLOT_W),
        .DEF_SLICE (DEF_SLICE)
    ) i_table (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .slot_i    (cur_slot),
        .len_o     (len),
        .sel_o     (sel)
    );

    for (genvar c = 0; c < NUM_CTRS; c++) begin : g_lane
        mcb_lane #(
            .NUM_EVENTS (NUM_EVENTS),
            .SEL_W      (SEL_W),
            .CTR_W      (CTR_W)
        ) i_lane (
            .clk      (clk),
            .rst      (rst),
            .ev_i     (ev_i),
            .sel_i    (sel[c]),
            .evt_i    (evt),
            .valid_o  (valid[c]),
            .credit_o (credit[c])
        );
    end

    mcb_shadow #(
        .NUM_EVENTS (NUM_EVENTS),
        .NUM_CTRS   (NUM_CTRS),
        .SEL_W      (SEL_W),
        .CTR_W      (CTR_W),
        .TOT_W      (TOT_W)
    ) i_shadow (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .sel_i    (sel),
        .valid_i  (valid),
        .credit_i (credit),
        .rd_idx   (rd_idx),
        .rd_total (rd_total)
    );

endmodule

// File: rtl/mcb_checker.sv
module mcb_checker #(
    parameter int NUM_EVENTS = 24,
    parameter int NUM_SLOTS  = 4,
    parameter int SEL_W      = 5,
    parameter int SLOT_W     = 2,
    parameter int TOT_W      = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  rd_idx,
    input logic [TOT_W-1:0]  rd_total,
    input logic [SLOT_W-1:0] cur_slot,
    input logic              sweep_done
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    // R6: the active slot stays inside the rotation.
    p_slot_bound_r6: assert property (@(posedge clk) disable iff (rst)
        32'(cur_slot) < NUM_SLOTS);

    // R6: a slot change is a single step forward or a wrap to zero.
    p_slot_step_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_slot != $past(cur_slot)) |->
            (($past(cur_slot) == LAST) ? (cur_slot == '0)
                                       : (cur_slot == $past(cur_slot) + SLOT_W'(1))));

    // R7: the sweep pulse follows a wrap from the last slot.
    p_done_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        sweep_done |-> (cur_slot == '0 && $past(cur_slot) == LAST));

    // R7: the sweep pulse lasts one cycle.
    if (NUM_SLOTS > 1) begin : g_pulse
        p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
            sweep_done |=> !sweep_done);
    end

    // R10: reads outside the event range return zero.
    p_rd_oob_r10: assert property (@(posedge clk) disable iff (rst)
        (32'(rd_idx) >= NUM_EVENTS) |-> (rd_total == '0));

endmodule

bind mux_event_counter_bank mcb_checker #(
    .NUM_EVENTS (NUM_EVENTS),
    .NUM_SLOTS  (NUM_SLOTS),
    .SEL_W      (SEL_W),
    .SLOT_W     (SLOT_W),
    .TOT_W      (TOT_W)
) i_mcb_checker (
    .clk        (clk),
    .rst        (rst),
    .rd_idx     (rd_idx),
    .rd_total   (rd_total),
    .cur_slot   (cur_slot),
    .sweep_done (sweep_done)
);

// File: tb/test_mux_event_counter_bank.sv
`timescale 1ns/1ps
module test_mux_event_counter_bank;

    localparam int CLK_PERIOD = 100;
    localparam int NE      = 24;
    localparam int NC      = 15;
    localparam int NS      = 4;
    localparam int CTR_W   = 4;
    localparam int TOT_W   = 20;
    localparam int SLICE_W = 8;
    localparam int DEF_SL  = 6;
    localparam int SEL_W   = $clog2(NE + 1);
    localparam int SLOT_W  = $clog2(NS);
    localparam int ADDR_W  = $clog2(NS * NC + 1);
    localparam int CMAX    = (1 << CTR_W) - 1;
    localparam longint TMASK = (longint'(1) << TOT_W) - 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NE-1:0]       ev_i = '0;
    logic                cfg_we = 1'b0;
    logic [ADDR_W-1:0]   cfg_addr = '0;
    logic [SLICE_W-1:0]  cfg_wdata = '0;
    logic [SEL_W-1:0]    rd_idx = '0;
    logic [TOT_W-1:0]    rd_total;
    logic [SLOT_W-1:0]   cur_slot;
    logic                sweep_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // Reference state, updated from the requirements at each rising edge.
    int     m_len;
    int     m_sel [NS][NC];
    int     m_cnt [NC];
    longint m_tot [NE];
    int     m_tick, m_slot;
    bit     m_done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mux_event_counter_bank #(
        .NUM_EVENTS (NE), .NUM_CTRS (NC), .NUM_SLOTS (NS),
        .CTR_W (CTR_W), .TOT_W (TOT_W), .SLICE_W (SLICE_W), .DEF_SLICE (DEF_SL)
    ) i_mux_event_counter_bank (
        .clk (clk), .rst (rst), .ev_i (ev_i),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
        .rd_idx (rd_idx), .rd_total (rd_total),
        .cur_slot (cur_slot), .sweep_done (sweep_done)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_len = DEF_SL;
            for (int s = 0; s < NS; s++)
                for (int c = 0; c < NC; c++) m_sel[s][c] = (1 << SEL_W) - 1;
            for (int c = 0; c < NC; c++) m_cnt[c] = 0;
            for (int e = 0; e < NE; e++) m_tot[e] = 0;
            m_tick = 0; m_slot = 0; m_done = 0;
        end else begin
            int  le, sv, v;
            bit  bnd;
            le  = (m_len == 0) ? 1 : m_len;
            bnd = (m_tick >= le - 1);
            for (int c = 0; c < NC; c++) begin
                sv = m_sel[m_slot][c];
                v  = m_cnt[c] + ((sv < NE && ev_i[sv]) ? 1 : 0);
                if (v > CMAX) v = CMAX;
                if (bnd) begin
                    if (sv < NE) m_tot[sv] = (m_tot[sv] + v) & TMASK;
                    m_cnt[c] = 0;
                end else m_cnt[c] = v;
            end
            if (bnd) begin
                m_done = (m_slot == NS - 1);
                m_slot = (m_slot + 1) % NS;
                m_tick = 0;
            end else begin
                m_tick++;
                m_done = 0;
            end
            if (cfg_we) begin
                if (cfg_addr == 0) m_len = int'(cfg_wdata);
                else if (int'(cfg_addr) <= NS * NC)
                    m_sel[(int'(cfg_addr) - 1) / NC][(int'(cfg_addr) - 1) % NC] =
                        int'(cfg_wdata) & ((1 << SEL_W) - 1);
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock; slot and sweep outputs compared at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (!rst) begin
            chk("R3/R6 slot", cur_slot, m_slot);
            chk("R7 sweep_done", sweep_done, m_done);
        end
    endtask

    task automatic check_totals(input string req);
        for (int e = 0; e < NE; e++) begin
            rd_idx = SEL_W'(e);
            #1;
            chk(req, rd_total, m_tot[e]);
        end
    endtask

    task automatic cfg_write(input int addr, input int data);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(addr); cfg_wdata = SLICE_W'(data);
        step();
        cfg_we = 1'b0;
    endtask

    // mode 0: random, 1: all ones, 2: all zeros
    task automatic run(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            case (mode)
                0: ev_i = NE'({$urandom, $urandom});
                1: ev_i = '1;
                default: ev_i = '0;
            endcase
            step();
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: state right after reset
        chk("R1 slot after reset", cur_slot, 0);
        chk("R1 sweep_done after reset", sweep_done, 0);
        check_totals("R1 totals after reset");
        rst = 1'b0;

        // R5: reset selections are idle, no total moves
        run(30, 1);
        check_totals("R5 idle reset selections");

        // R2/R4: program length and a full table, then count random events
        cfg_write(0, 5);
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < NC; c++)
                cfg_write(1 + s * NC + c, (s * 7 + c) % NE);
        run(80, 0);
        check_totals("R4 slice crediting");

        // R9: four counters of slot 2 watch the same event
        for (int c = 0; c < 4; c++) cfg_write(1 + 2 * NC + c, 7);
        run(40, 1);
        check_totals("R9 shared event");

        // R5: invalid selections in slot 1
        for (int c = 0; c < 6; c++) cfg_write(1 + NC + c, NE + c);
        cfg_write(1 + NC + 6, 31);
        run(40, 0);
        check_totals("R5 invalid selections");

        // R8: long slices with every event high saturate the counters
        cfg_write(0, 40);
        run(200, 1);
        check_totals("R8 saturation");

        // R2/R3: length 0 acts as 1, a boundary every cycle
        cfg_write(0, 0);
        run(16, 0);
        check_totals("R3 single-cycle slices");
        cfg_write(0, 1);
        run(12, 1);
        check_totals("R3 length one");

        // R2: writes above the table are ignored
        cfg_write(0, 3);
        cfg_write(NS * NC + 1, 2);
        cfg_write(NS * NC + 2, 200);
        cfg_write((1 << ADDR_W) - 1, 0);
        run(30, 1);
        check_totals("R2 ignored addresses");

        // R10: reads past the last event return zero
        for (int k = NE; k < (1 << SEL_W); k++) begin
            rd_idx = SEL_W'(k);
            #1;
            chk("R10 out-of-range read", rd_total, 0);
        end

        // R11: random traffic with mid-slice reconfiguration
        for (int seg = 0; seg < 12; seg++) begin
            int dens;
            dens = seg % 4;
            for (int i = 0; i < 250; i++) begin
                logic [NE-1:0] a, b;
                a = NE'({$urandom, $urandom});
                b = NE'({$urandom, $urandom});
                case (dens)
                    0: ev_i = a & b;
                    1: ev_i = a;
                    2: ev_i = a | b;
                    default: ev_i = '1;
                endcase
                if ($urandom_range(99) < 4) begin
                    int ad;
                    ad = $urandom_range((1 << ADDR_W) - 1);
                    cfg_we = 1'b1;
                    cfg_addr = ADDR_W'(ad);
                    cfg_wdata = (ad == 0) ? SLICE_W'($urandom_range(9))
                                          : SLICE_W'($urandom);
                end
                step();
                cfg_we = 1'b0;
            end
            check_totals("R11 random reconfiguration");
        end

        // R1: reset in the middle of a run
        rst = 1'b1;
        step();
        step();
        chk("R1 slot after mid-run reset", cur_slot, 0);
        chk("R1 sweep_done after mid-run reset", sweep_done, 0);
        check_totals("R1 totals after mid-run reset");
        rst = 1'b0;
        run(20, 1);
        check_totals("R1 idle after mid-run reset");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule